// File: doc/BRIEF.md
# Saturating Decimal Up/Down Event Counter

This block keeps a decimal event count between 0 and 999. It has separate count-up and count-down strobes, a load strobe that takes a three-digit BCD preset, and a level-sensitive clear. The three strobes are ordinary level signals from elsewhere in the chip. The block compares each one against its value at the previous clock edge, so a count, decrement or load happens once per 0-to-1 transition, however long the signal then stays high.

The count is held as a binary integer. It is reported on two output buses: once in binary and once as packed BCD digits. A flag output shows whether the count is nonzero. The count stops at both ends of its range and never wraps. When an up transition and a down transition arrive at the same clock edge, they cancel.

The block fits wherever a small decimal tally is needed, for example a part counter on a production line or a display-facing event total. The system clock must be fast enough that no strobe pulses high and low between two clock edges.

Top module: `sat_bcd_counter`

## Requirements
- R1: `count_bin_o` always lies between 0 and 999 inclusive.
- R2: A 0-to-1 transition on `ld_i` loads `preset_bcd_i` into the count. The preset holds units in bits 3:0, tens in bits 7:4 and hundreds in bits 11:8.
- R3: If any preset digit is greater than 9, a load sets the count to 999.
- R4: A 0-to-1 transition on `up_i` adds one to the count. When the count is 999, the transition is ignored and the count stays at 999.
- R5: A 0-to-1 transition on `dn_i` subtracts one from the count. When the count is 0, the transition is ignored and the count stays at 0.
- R6: When transitions on `up_i` and `dn_i` are seen at the same clock edge, the count is left unchanged.
- R7: At every clock edge where `clr_i` is high, the count becomes 0.
- R8: When several controls are active at one clock edge, `clr_i` takes priority over a load, and a load takes priority over counting.
- R9: A strobe acts only at the first clock edge where it is sampled high after being sampled low. Holding it high causes no further steps, and between loads and clears the count moves by at most one per clock.
- R10: `nonzero_o` is 1 exactly when the count is nonzero.
- R11: `count_bcd_o` gives the same count as `count_bin_o`, using the same digit layout as the preset.
- R12: The synchronous reset `rst` clears the count and the stored previous strobe samples. A strobe that is already high when reset is released therefore counts as a transition at the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every action happens on its rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| up_i | input | 1 | Count-up strobe; acts on its rising transition |
| dn_i | input | 1 | Count-down strobe; acts on its rising transition |
| ld_i | input | 1 | Load strobe; acts on its rising transition |
| clr_i | input | 1 | Level clear; forces the count to 0 |
| preset_bcd_i | input | 12 | Three-digit packed BCD preset value |
| count_bin_o | output | 10 | Current count as a binary integer |
| count_bcd_o | output | 12 | Current count as packed BCD digits |
| nonzero_o | output | 1 | High when the count is not 0 |

## Verification
A corrupted count register shows up on all three outputs one cycle after the bad clock edge. The binary and BCD buses then no longer agree with the step that the bench predicted. A stale previous-sample register shows up in a different way. A held strobe either adds a second step, or a genuine transition is lost, and either fault is visible in the cycle right after the strobe is driven. Faults at the saturation points and in the control priority only appear at a boundary. For that reason the vectors drive up at 999, down at 0, both strobes together, and clear against load at the clock edge where each conflict arises.

// File: rtl/sat_cnt_pkg.sv
package sat_cnt_pkg;

    localparam int DIGITS    = 3;
    localparam int BCD_W     = 4 * DIGITS;
    localparam int MAX_COUNT = (10 ** DIGITS) - 1;
    localparam int CNT_W     = $clog2(MAX_COUNT + 1);
    localparam int NUM_EDGE  = 3;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [BCD_W-1:0] bcd_t;

    // Strobe bit positions inside the edge detector vector
    localparam int EDGE_UP = 0;
    localparam int EDGE_DN = 1;
    localparam int EDGE_LD = 2;

    typedef struct packed {
        logic clr;
        logic ld;
        logic up;
        logic dn;
    } ctrl_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_LOAD,
        OP_INC,
        OP_DEC
    } op_e;

    // Packed BCD to binary; any digit above nine saturates to the maximum
    function automatic count_t bcd_to_count(bcd_t b);
        int acc;
        logic bad;
        logic [3:0] nib;
        acc = 0;
        bad = 1'b0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            nib = b[4*i +: 4];
            if (nib > 4'd9) bad = 1'b1;
            acc = acc * 10 + int'(nib);
        end
        if (bad) return count_t'(MAX_COUNT);
        return count_t'(acc);
    endfunction

    // Binary to packed BCD by repeated constant division
    function automatic bcd_t count_to_bcd(count_t c);
        int v;
        bcd_t r;
        v = int'(c);
        r = '0;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b0;
            else     prev_q[g] <= level_i[g];
        end
        assign rise_o[g] = level_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/preset_decode.sv
module preset_decode
    import sat_cnt_pkg::*;
(
    input  bcd_t   preset_i,
    output count_t value_o
);
    always_comb value_o = bcd_to_count(preset_i);
endmodule

// File: rtl/count_core.sv
module count_core
    import sat_cnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctrl_t  ev_i,
    input  count_t load_val_i,
    output count_t count_o
);
    localparam count_t TOP = count_t'(MAX_COUNT);

    count_t cnt_q;
    op_e    op;

    always_comb begin
        if (ev_i.clr)                                  op = OP_CLEAR;
        else if (ev_i.ld)                              op = OP_LOAD;
        else if (ev_i.up && !ev_i.dn && cnt_q != TOP)  op = OP_INC;
        else if (ev_i.dn && !ev_i.up && cnt_q != '0)   op = OP_DEC;
        else                                           op = OP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (op)
                OP_CLEAR: cnt_q <= '0;
                OP_LOAD:  cnt_q <= load_val_i;
                OP_INC:   cnt_q <= cnt_q + count_t'(1);
                OP_DEC:   cnt_q <= cnt_q - count_t'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/sat_bcd_counter.sv
module sat_bcd_counter
    import sat_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               up_i,
    input  logic               dn_i,
    input  logic               ld_i,
    input  logic               clr_i,
    input  logic [BCD_W-1:0]   preset_bcd_i,
    output logic [CNT_W-1:0]   count_bin_o,
    output logic [BCD_W-1:0]   count_bcd_o,
    output logic               nonzero_o
);
    logic [NUM_EDGE-1:0] levels;
    logic [NUM_EDGE-1:0] rises;
    ctrl_t               ev;
    count_t              load_val;
    count_t              count;

    assign levels[EDGE_UP] = up_i;
    assign levels[EDGE_DN] = dn_i;
    assign levels[EDGE_LD] = ld_i;

    rise_detect #(.W(NUM_EDGE)) i_rise (
        .clk     (clk),
        .rst     (rst),
        .level_i (levels),
        .rise_o  (rises)
    );

    preset_decode i_dec (
        .preset_i (preset_bcd_i),
        .value_o  (load_val)
    );

    always_comb begin
        ev.clr = clr_i;
        ev.ld  = rises[EDGE_LD];
        ev.up  = rises[EDGE_UP];
        ev.dn  = rises[EDGE_DN];
    end

    count_core i_core (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .load_val_i (load_val),
        .count_o    (count)
    );

    assign count_bin_o = count;
    assign count_bcd_o = count_to_bcd(count);
    assign nonzero_o   = |count;
endmodule

// File: rtl/sat_cnt_chk.sv
module sat_cnt_chk
    import sat_cnt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             up_i,
    input logic             dn_i,
    input logic             ld_i,
    input logic             clr_i,
    input logic [BCD_W-1:0] preset_bcd_i,
    input logic [CNT_W-1:0] count_bin_o,
    input logic [BCD_W-1:0] count_bcd_o,
    input logic             nonzero_o
);
    localparam count_t TOP = count_t'(MAX_COUNT);

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(count_bin_o) <= MAX_COUNT);  // R1

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> count_bin_o == '0);  // R7

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (count_bin_o == TOP && !clr_i && !ld_i) |=> count_bin_o != '0);  // R4

    AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (count_bin_o == '0 && !clr_i && !ld_i) |=> count_bin_o != TOP);  // R5

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !ld_i) |=>
            (int'(count_bin_o) - int'($past(count_bin_o)) <= 1 &&
             int'($past(count_bin_o)) - int'(count_bin_o) <= 1));  // R9

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        nonzero_o == (count_bin_o != '0));  // R10

    AST_BCD_AGREES: assert property (@(posedge clk) disable iff (rst)
        bcd_to_count(count_bcd_o) == count_bin_o);  // R11

endmodule

bind sat_bcd_counter sat_cnt_chk i_chk (.*);

// File: tb/test_sat_bcd_counter.sv
module test_sat_bcd_counter;

    logic        clk = 1'b0;
    logic        rst;
    logic        up_i, dn_i, ld_i, clr_i;
    logic [11:0] preset_bcd_i;
    logic [9:0]  count_bin_o;
    logic [11:0] count_bcd_o;
    logic        nonzero_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sat_bcd_counter i_sat_bcd_counter (.*);

    typedef struct packed {
        logic        up;
        logic        dn;
        logic        ld;
        logic        clr;
        logic [11:0] pre;
        logic [9:0]  exp;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'h127, 10'd127},  // R2 load
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 10'd127},
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 10'd128},  // R4
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 10'd128},  // R9 held
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 10'd128},
        '{1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 10'd127},  // R5
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 10'd127},
        '{1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 10'd127},  // R6
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 10'd127},
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'h999, 10'd999},  // R2
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 10'd999},  // R4 at top
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 10'd999},
        '{1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 10'd998},  // R5
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 10'd999},  // R4
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 10'd0},    // R2 zero preset
        '{1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 10'd0},    // R5 at bottom
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 10'd1},    // R4
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'h9A5, 10'd999},  // R3 bad digit
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 10'd0},    // R7 R8 clear beats up
        '{1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 10'd0},    // R7
        '{1'b1, 1'b0, 1'b1, 1'b0, 12'h055, 10'd55},   // R8 load beats up
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 10'd55},
        '{1'b0, 1'b0, 1'b1, 1'b1, 12'h300, 10'd0},    // R8 clear beats load
        '{1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 10'd0}
    };

    function automatic logic [11:0] dec_bcd(int v);
        return {4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check_count(string req, int exp);
        checks++;
        if (int'(count_bin_o) != exp || count_bcd_o != dec_bcd(exp) ||
            nonzero_o != (exp != 0)) begin
            failures++;
            $display("FAIL %s: bin=%0d bcd=%h nz=%0b expected bin=%0d bcd=%h nz=%0b",
                     req, count_bin_o, count_bcd_o, nonzero_o,
                     exp, dec_bcd(exp), exp != 0);
        end
    endtask

    initial begin
        rst = 1'b1; up_i = 0; dn_i = 0; ld_i = 0; clr_i = 0; preset_bcd_i = '0;
        repeat (3) @(negedge clk);
        check_count("R12 reset state, R10 R11", 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            up_i = VEC[i].up; dn_i = VEC[i].dn; ld_i = VEC[i].ld;
            clr_i = VEC[i].clr; preset_bcd_i = VEC[i].pre;
            @(negedge clk);
            check_count($sformatf("R1-table vector %0d (R2 R3 R4 R5 R6 R7 R8 R9)", i),
                        int'(VEC[i].exp));
        end

        // R12: reset clears the count and the strobe history
        ld_i = 1; preset_bcd_i = 12'h042; up_i = 0; dn_i = 0; clr_i = 0;
        @(negedge clk);
        check_count("R2 load 42", 42);
        ld_i = 0; up_i = 1; rst = 1;
        repeat (2) @(negedge clk);
        check_count("R12 reset clears count", 0);
        rst = 0;
        @(negedge clk);
        check_count("R12 held strobe counts after reset", 1);
        up_i = 0;
        @(negedge clk);
        check_count("R9 no extra step", 1);

        // R4: walk up to the top and try to pass it
        ld_i = 1; preset_bcd_i = 12'h996;
        @(negedge clk);
        check_count("R2 load 996", 996);
        ld_i = 0;
        for (int k = 0; k < 5; k++) begin
            up_i = 1;
            @(negedge clk);
            check_count("R4 saturating walk", (997 + k > 999) ? 999 : 997 + k);
            up_i = 0;
            @(negedge clk);
        end

        // R5: walk down below zero
        ld_i = 1; preset_bcd_i = 12'h002;
        @(negedge clk);
        ld_i = 0;
        for (int k = 0; k < 4; k++) begin
            dn_i = 1;
            @(negedge clk);
            check_count("R5 saturating walk", (1 - k < 0) ? 0 : 1 - k);
            dn_i = 0;
            @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule